// File: doc/BRIEF.md
# Push-Button Menu Configuration Controller

This block runs a small nested menu driven by four debounced push buttons and shows its state on eight LEDs. From the main menu the user can open a system-mode submenu (genlock, pass-through or standalone), a datapath submenu that is unsupported, a video-format submenu or a clock-frequency submenu. In the format and frequency submenus the user steps a pending code up or down, then confirms it or cancels.

A confirmed choice is reported by whole-bank LED flashes. One flash means success and two flashes mean failure. After the flashes the block goes back to the main menu. Mode changes, and format or frequency changes that are valid in standalone mode, raise a one-cycle apply strobe. The block then waits for the downstream system to answer with done or fail, or for a timeout. The committed mode, format code and frequency code are held on output ports.

Each button is a one-cycle press pulse. All blink and flash timing comes from one tick prescaler of `TICK_DIV` clock cycles. The default is 250 ms at 250 MHz.

Top module: `menu_cfg_ctrl`

## Requirements
- R1: After reset the mode is standalone (mode code 0), the format and frequency codes are 0, apply is low and the LED bank reads 8'h80 (bit 7 = standalone lamp, bit 0 dark).
- R2: Each menu blinks its own lamp: main menu bit 0, system-mode menu bit 1, format menu bit 2 and frequency menu bit 3. On menu entry the lamp starts dark, and it toggles every `TICK_DIV` cycles.
- R3: In the main menu button 0 opens the system-mode menu. There button 1 selects genlock (code 1), button 2 selects pass-through (code 2) and button 3 selects standalone (code 0). The mode output updates, apply pulses for exactly one cycle, and lamp bits 5/6/7 show genlock, pass-through and standalone one-hot.
- R4: After an apply, done gives one flash. Fail, or `WAIT_LIM` cycles with no answer, gives two flashes.
- R5: A flash drives all eight LEDs on for `TICK_DIV` cycles, then all off for `TICK_DIV` cycles. During a flash sequence the bank is never partly lit.
- R6: Button 1 in the main menu (datapath) gives two flashes at once. It changes no mode, code or apply.
- R7: Button 2 steps the pending code up and button 3 steps it down, with wrap-around. Format codes run 0..11 (11 wraps up to 0) and frequency codes run 0..4.
- R8: Button 0 in the format or frequency menu returns to the main menu with no flash and leaves the stored code unchanged.
- R9: The format/frequency pair is compatible when one of these holds:
  - frequency 0 (SD) with format 0..1;
  - frequency 2 (HD integer rate) with format 2..9;
  - frequency 1 (HD 1/1.001 rate) with format 3, 4, 6, 7 or 9;
  - frequency 4 (3G integer rate) with format 10..11;
  - frequency 3 (3G 1/1.001 rate) with format 11.
- R10: In standalone mode a confirm always stores the pending code. A compatible pair then applies and waits as in R4. An incompatible pair gives two flashes with no apply.
- R11: In genlock or pass-through mode a confirm stores the code and gives one flash with no apply.
- R12: When several buttons are pressed in the same cycle, the lowest-numbered button wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| btn_i | input | 4 | Debounced one-cycle button press pulses |
| sys_done_i | input | 1 | Downstream configuration finished |
| sys_fail_i | input | 1 | Downstream configuration failed |
| led_o | output | 8 | Status lamps, bit 0 = lamp 1 |
| mode_o | output | 2 | Committed mode: 0 standalone, 1 genlock, 2 pass-through |
| fmt_o | output | 4 | Committed video format code |
| freq_o | output | 3 | Committed clock frequency code |
| apply_o | output | 1 | One-cycle strobe asking the system to reconfigure |

## Verification
The compatibility check is tried with a table of format/frequency pairs, each reached through real menu navigation. The table has pairs on both sides of every rate-family boundary (SD/HD, HD/3G) and of every 1/1.001 boundary, so the apply strobe and the one-or-two flash result separate an accepted pair from a rejected one. The mode menu is tried with each of the three downstream answers (done, fail, silence), which separates the success path from the timeout path. Cancel, datapath entry, wrap-around stepping in both directions, simultaneous presses and confirms outside standalone mode are each driven on their own, so a fault in that path cannot be hidden by the main flow.

// File: rtl/menu_pkg.sv
`timescale 1ns/1ps
package menu_pkg;
  localparam int FMT_W    = 4;
  localparam int FRQ_W    = 3;
  localparam int FMT_LAST = 11;
  localparam int FRQ_LAST = 4;

  localparam logic [1:0] MD_ALONE = 2'd0;
  localparam logic [1:0] MD_GLOCK = 2'd1;
  localparam logic [1:0] MD_PASS  = 2'd2;

  typedef enum logic [2:0] {
    ST_MAIN, ST_SYS, ST_FMT, ST_FRQ, ST_WAIT, ST_FLASH
  } menu_st_t;

  // rate-family and 1/1.001 compatibility of a format/frequency pair
  function automatic logic pair_ok(input logic [FMT_W-1:0] f, input logic [FRQ_W-1:0] q);
    logic ok;
    case (q)
      3'd0:    ok = (f <= 4'd1);
      3'd1:    ok = (f == 4'd3) || (f == 4'd4) || (f == 4'd6) || (f == 4'd7) || (f == 4'd9);
      3'd2:    ok = (f >= 4'd2) && (f <= 4'd9);
      3'd3:    ok = (f == 4'd11);
      3'd4:    ok = (f == 4'd10) || (f == 4'd11);
      default: ok = 1'b0;
    endcase
    return ok;
  endfunction
endpackage

// File: rtl/menu_tick.sv
`timescale 1ns/1ps
module menu_tick #(
  parameter int DIV = 4
) (
  input  logic clk_i,
  input  logic rst_n,
  input  logic clr_i,
  output logic tick_o
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;

  logic [CW-1:0] cnt_q, cnt_d;

  assign tick_o = (cnt_q == CW'(DIV - 1));

  always_comb begin
    if (clr_i || tick_o) cnt_d = '0;
    else                 cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  generate
    if (DIV > 1) begin : g_gap
      // R5
      tick_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
        tick_o |=> !tick_o);
    end
  endgenerate
endmodule

// File: rtl/menu_code_sel.sv
`timescale 1ns/1ps
module menu_code_sel #(
  parameter int W    = 4,
  parameter int LAST = 11
) (
  input  logic         clk_i,
  input  logic         rst_n,
  input  logic         ld_i,
  input  logic [W-1:0] ld_val_i,
  input  logic         up_i,
  input  logic         dn_i,
  output logic [W-1:0] val_o
);
  logic [W-1:0] val_q, val_d;
  logic         en;

  assign en = ld_i || up_i || dn_i;

  always_comb begin
    if (ld_i)      val_d = ld_val_i;
    else if (up_i) val_d = (val_q == W'(LAST)) ? '0 : val_q + 1'b1;
    else           val_d = (val_q == '0) ? W'(LAST) : val_q - 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n)  val_q <= '0;
    else if (en) val_q <= val_d;
  end

  assign val_o = val_q;

  // R7
  range_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    val_q <= W'(LAST));
  // R7
  wrap_up_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    (up_i && !ld_i && val_q == W'(LAST)) |=> (val_q == '0));
  // R7
  wrap_dn_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    (dn_i && !up_i && !ld_i && val_q == '0) |=> (val_q == W'(LAST)));
endmodule

// File: rtl/menu_cfg_ctrl.sv
`timescale 1ns/1ps
module menu_cfg_ctrl
  import menu_pkg::*;
#(
  parameter int TICK_DIV = 62_500_000,
  parameter int WAIT_LIM = 1_000_000
) (
  input  logic             clk_i,
  input  logic             rst_n,
  input  logic [3:0]       btn_i,
  input  logic             sys_done_i,
  input  logic             sys_fail_i,
  output logic [7:0]       led_o,
  output logic [1:0]       mode_o,
  output logic [FMT_W-1:0] fmt_o,
  output logic [FRQ_W-1:0] freq_o,
  output logic             apply_o
);
  localparam int WCW = $clog2(WAIT_LIM + 1);

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rsync_q;
  logic       rst_s;
  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_s = rsync_q[1];

  menu_st_t         st, st_n;
  logic [1:0]       mode_q, mode_n;
  logic [FMT_W-1:0] fmt_q, fmt_n, fmt_pend;
  logic [FRQ_W-1:0] frq_q, frq_n, frq_pend;
  logic             two_q, two_n, apply_q, apply_n;
  logic             blink_q;
  logic [1:0]       ph_q;
  logic [WCW-1:0]   wait_q;
  logic             tick, st_chg, wait_hit;
  logic             fmt_ld, f_up, f_dn, frq_ld, q_up, q_dn;

  assign st_chg   = (st_n != st);
  assign wait_hit = (wait_q == WCW'(WAIT_LIM - 1));

  menu_tick #(.DIV(TICK_DIV)) u_tick (
    .clk_i(clk_i), .rst_n(rst_s), .clr_i(st_chg), .tick_o(tick)
  );

  menu_code_sel #(.W(FMT_W), .LAST(FMT_LAST)) u_fmt_sel (
    .clk_i(clk_i), .rst_n(rst_s), .ld_i(fmt_ld), .ld_val_i(fmt_q),
    .up_i(f_up), .dn_i(f_dn), .val_o(fmt_pend)
  );

  menu_code_sel #(.W(FRQ_W), .LAST(FRQ_LAST)) u_frq_sel (
    .clk_i(clk_i), .rst_n(rst_s), .ld_i(frq_ld), .ld_val_i(frq_q),
    .up_i(q_up), .dn_i(q_dn), .val_o(frq_pend)
  );

  // next-state logic
  always_comb begin
    st_n = st; mode_n = mode_q; fmt_n = fmt_q; frq_n = frq_q;
    two_n = two_q; apply_n = 1'b0;
    fmt_ld = 1'b0; f_up = 1'b0; f_dn = 1'b0;
    frq_ld = 1'b0; q_up = 1'b0; q_dn = 1'b0;
    case (st)
      ST_MAIN: begin
        if (btn_i[0])      st_n = ST_SYS;
        else if (btn_i[1]) begin st_n = ST_FLASH; two_n = 1'b1; end
        else if (btn_i[2]) begin st_n = ST_FMT; fmt_ld = 1'b1; end
        else if (btn_i[3]) begin st_n = ST_FRQ; frq_ld = 1'b1; end
      end
      ST_SYS: begin
        if (btn_i[0]) st_n = ST_MAIN;
        else if (btn_i[3:1] != 3'b000) begin
          mode_n  = btn_i[1] ? MD_GLOCK : (btn_i[2] ? MD_PASS : MD_ALONE);
          apply_n = 1'b1;
          st_n    = ST_WAIT;
        end
      end
      ST_FMT, ST_FRQ: begin
        if (btn_i[0]) st_n = ST_MAIN;
        else if (btn_i[1]) begin
          if (st == ST_FMT) fmt_n = fmt_pend;
          else              frq_n = frq_pend;
          if (mode_q != MD_ALONE) begin
            st_n = ST_FLASH; two_n = 1'b0;
          end else if (pair_ok((st == ST_FMT) ? fmt_pend : fmt_q,
                               (st == ST_FRQ) ? frq_pend : frq_q)) begin
            st_n = ST_WAIT; apply_n = 1'b1;
          end else begin
            st_n = ST_FLASH; two_n = 1'b1;
          end
        end else if (btn_i[2]) begin
          f_up = (st == ST_FMT); q_up = (st == ST_FRQ);
        end else if (btn_i[3]) begin
          f_dn = (st == ST_FMT); q_dn = (st == ST_FRQ);
        end
      end
      ST_WAIT: begin
        if (sys_done_i) begin st_n = ST_FLASH; two_n = 1'b0; end
        else if (sys_fail_i || wait_hit) begin st_n = ST_FLASH; two_n = 1'b1; end
      end
      ST_FLASH: begin
        if (tick && ph_q == (two_q ? 2'd3 : 2'd1)) st_n = ST_MAIN;
      end
      default: st_n = ST_MAIN;
    endcase
  end

  // state registers
  always_ff @(posedge clk_i or negedge rst_s) begin
    if (!rst_s) begin
      st <= ST_MAIN; mode_q <= MD_ALONE; fmt_q <= '0; frq_q <= '0;
      two_q <= 1'b0; apply_q <= 1'b0; blink_q <= 1'b0; ph_q <= 2'd0; wait_q <= '0;
    end else begin
      st <= st_n; mode_q <= mode_n; fmt_q <= fmt_n; frq_q <= frq_n;
      two_q <= two_n; apply_q <= apply_n;
      if (st_chg) begin
        blink_q <= 1'b0; ph_q <= 2'd0;
      end else if (tick) begin
        blink_q <= ~blink_q; ph_q <= ph_q + 2'd1;
      end
      if (st != ST_WAIT)  wait_q <= '0;
      else if (!wait_hit) wait_q <= wait_q + 1'b1;
    end
  end

  // lamps
  always_comb begin
    led_o    = 8'h00;
    led_o[5] = (mode_q == MD_GLOCK);
    led_o[6] = (mode_q == MD_PASS);
    led_o[7] = (mode_q == MD_ALONE);
    case (st)
      ST_MAIN:  led_o[0] = blink_q;
      ST_SYS:   led_o[1] = blink_q;
      ST_FMT:   led_o[2] = blink_q;
      ST_FRQ:   led_o[3] = blink_q;
      ST_FLASH: led_o    = ph_q[0] ? 8'h00 : 8'hFF;
      default:  ;
    endcase
  end

  assign mode_o  = mode_q;
  assign fmt_o   = fmt_q;
  assign freq_o  = frq_q;
  assign apply_o = apply_q;

  // R3
  apply_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_s)
    apply_q |=> !apply_q);
  // R5
  flash_bank_chk: assert property (@(posedge clk_i) disable iff (!rst_s)
    (st == ST_FLASH) |-> (led_o == 8'h00 || led_o == 8'hFF));
  // R6
  dp_fail_chk: assert property (@(posedge clk_i) disable iff (!rst_s)
    (st == ST_MAIN && btn_i == 4'b0010) |=> (st == ST_FLASH && two_q && !apply_q));
  // R8
  cancel_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_s)
    ((st == ST_FMT || st == ST_FRQ) && btn_i[0]) |=>
      (st == ST_MAIN && fmt_q == $past(fmt_q) && frq_q == $past(frq_q)));
  // R4
  done_one_chk: assert property (@(posedge clk_i) disable iff (!rst_s)
    (st == ST_WAIT && sys_done_i) |=> (st == ST_FLASH && !two_q));
  // R3
  mode_lamp_chk: assert property (@(posedge clk_i) disable iff (!rst_s)
    (st != ST_FLASH) |-> $onehot(led_o[7:5]));
endmodule

// File: tb/menu_cfg_ctrl_tb.sv
`timescale 1ns/1ps
module menu_cfg_ctrl_tb;
  localparam int DIV  = 4;
  localparam int WLIM = 20;
  localparam int NV   = 11;
  // {format[7:4], frequency[3:1], expected compatible[0]}
  localparam logic [7:0] VEC [NV] = '{
    {4'd1, 3'd0, 1'b1}, {4'd2, 3'd2, 1'b1}, {4'd2, 3'd1, 1'b0}, {4'd3, 3'd1, 1'b1},
    {4'd8, 3'd2, 1'b1}, {4'd8, 3'd1, 1'b0}, {4'd10, 3'd4, 1'b1}, {4'd10, 3'd3, 1'b0},
    {4'd11, 3'd3, 1'b1}, {4'd7, 3'd1, 1'b1}, {4'd0, 3'd0, 1'b1}};

  logic       clk = 1'b0;
  logic       rst_n;
  logic [3:0] btn;
  logic       done, fail;
  logic [7:0] led;
  logic [1:0] mode;
  logic [3:0] fmt;
  logic [2:0] freq;
  logic       apply;

  menu_cfg_ctrl #(.TICK_DIV(DIV), .WAIT_LIM(WLIM)) u_dut (
    .clk_i(clk), .rst_n(rst_n), .btn_i(btn), .sys_done_i(done), .sys_fail_i(fail),
    .led_o(led), .mode_o(mode), .fmt_o(fmt), .freq_o(freq), .apply_o(apply)
  );

  always #2 clk = ~clk;

  int n_chk = 0, n_bad = 0, applies = 0;
  int cur_fmt = 0, cur_frq = 0, cur_mode = 0;

  always @(posedge clk) if (apply) applies++;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic press(input logic [3:0] b);
    @(negedge clk) btn = b;
    @(negedge clk) btn = 4'b0000;
  endtask

  task automatic watch(input int len, output int fl, output int bad);
    int run = 0;
    fl = 0; bad = 0;
    for (int i = 0; i < len; i++) begin
      if (led == 8'hFF) run++;
      else begin
        if (run > 0) begin fl++; if (run != DIV) bad++; end
        run = 0;
      end
      @(negedge clk);
    end
    if (run > 0) fl++;
  endtask

  // count the cycles a lamp is lit over two tick periods
  task automatic lamp_on(input int bit_i, output int ones);
    ones = 0;
    for (int i = 0; i < 2 * DIV; i++) begin
      if (led[bit_i]) ones++;
      @(negedge clk);
    end
  endtask

  // press a committing button, then check apply and the flash count
  // resp: 0 done, 1 fail, 2 silent
  task automatic commit(input logic [3:0] b, input bit exp_apply, input int resp,
                        input int exp_fl, input string tag);
    int a0, fl, bad;
    a0 = applies;
    press(b);
    if (exp_apply) begin
      repeat (2) @(negedge clk);
      chk(applies - a0 == 1, {tag, " apply pulse"}, applies - a0, 1);
      if (resp == 0) begin @(negedge clk) done = 1'b1; @(negedge clk) done = 1'b0; end
      if (resp == 1) begin @(negedge clk) fail = 1'b1; @(negedge clk) fail = 1'b0; end
    end
    watch(40 + WLIM, fl, bad);
    if (!exp_apply) chk(applies == a0, {tag, " no apply"}, applies - a0, 0);
    chk(fl == exp_fl, {tag, " flash count"}, fl, exp_fl);
    chk(bad == 0, {tag, " R5 flash length"}, bad, 0);
  endtask

  function automatic bit model_ok(input int f, input int q);
    if (q == 0) return f == 0 || f == 1;
    if (q == 2) return f >= 2 && f <= 9;
    if (q == 1) return f == 3 || f == 4 || f == 6 || f == 7 || f == 9;
    if (q == 4) return f == 10 || f == 11;
    if (q == 3) return f == 11;
    return 1'b0;
  endfunction

  task automatic set_code(input bit is_fmt, input int target, input bit exp_ok);
    int m, cur, up;
    bit ok;
    m   = is_fmt ? 12 : 5;
    cur = is_fmt ? cur_fmt : cur_frq;
    up  = (target - cur + m) % m;
    press(is_fmt ? 4'b0100 : 4'b1000);
    if (2 * up <= m) for (int i = 0; i < up; i++) press(4'b0100);
    else             for (int i = 0; i < m - up; i++) press(4'b1000);
    if (is_fmt) cur_fmt = target; else cur_frq = target;
    ok = exp_ok;
    if (cur_mode != 0) commit(4'b0010, 1'b0, 0, 1, "R11 non-standalone confirm");
    else if (ok)       commit(4'b0010, 1'b1, 0, 1, "R9 R10 compatible pair");
    else               commit(4'b0010, 1'b0, 0, 2, "R9 R10 mismatched pair");
    if (is_fmt) chk(fmt == 4'(target), "R7 stored format", fmt, target);
    else        chk(freq == 3'(target), "R7 stored frequency", freq, target);
  endtask

  task automatic finish_run;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #(200000 * 4);
    n_bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int ones, fl, bad, a0;
    btn = 4'b0000; done = 1'b0; fail = 1'b0; rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    chk(led == 8'h80, "R1 reset lamps", led, 8'h80);
    chk(mode == 2'd0, "R1 reset mode", mode, 0);
    chk(fmt == 4'd0 && freq == 3'd0, "R1 reset codes", {fmt, freq}, 0);
    chk(apply == 1'b0, "R1 reset apply", apply, 0);

    // R7 wrap in both directions, in standalone mode
    set_code(1'b0, 4, model_ok(0, 4));
    set_code(1'b0, 0, model_ok(0, 0));
    set_code(1'b1, 11, model_ok(11, 0));
    set_code(1'b1, 0, model_ok(0, 0));

    // R9 R10 table walk
    for (int v = 0; v < NV; v++) begin
      set_code(1'b1, int'(VEC[v][7:4]), model_ok(int'(VEC[v][7:4]), cur_frq));
      set_code(1'b0, int'(VEC[v][3:1]), VEC[v][0]);
      chk(model_ok(cur_fmt, cur_frq) == VEC[v][0], "R9 table entry", v, v);
    end

    // R2 system-mode menu lamp
    press(4'b0001);
    lamp_on(1, ones);
    chk(ones == DIV, "R2 system menu lamp blink", ones, DIV);
    // R3 genlock, answered by done (R4)
    commit(4'b0010, 1'b1, 0, 1, "R3 R4 genlock done");
    chk(mode == 2'd1, "R3 genlock mode", mode, 1);
    chk(led[7:5] == 3'b001, "R3 genlock lamp", led[7:5], 1);
    cur_mode = 1;
    // R11 format change outside standalone
    set_code(1'b1, 5, 1'b1);
    // R3 pass-through, answered by fail (R4)
    press(4'b0001);
    commit(4'b0100, 1'b1, 1, 2, "R3 R4 pass-through fail");
    chk(mode == 2'd2, "R3 pass-through mode", mode, 2);
    chk(led[7:5] == 3'b010, "R3 pass-through lamp", led[7:5], 2);
    // R3 standalone, no answer -> timeout (R4)
    press(4'b0001);
    commit(4'b1000, 1'b1, 2, 2, "R3 R4 standalone timeout");
    chk(mode == 2'd0, "R3 standalone mode", mode, 0);
    cur_mode = 0;

    // R6 datapath entry
    commit(4'b0010, 1'b0, 0, 2, "R6 datapath");
    chk(mode == 2'd0 && fmt == 4'd5, "R6 state kept", {mode, fmt}, 5);

    // R8 cancel in the format menu and the frequency menu
    a0 = applies;
    press(4'b0100); press(4'b0100); press(4'b0100); press(4'b0001);
    watch(20, fl, bad);
    chk(fl == 0, "R8 format cancel no flash", fl, 0);
    chk(fmt == 4'd5, "R8 format kept", fmt, 5);
    lamp_on(0, ones);
    chk(ones == DIV, "R2 R8 back in main menu", ones, DIV);
    press(4'b1000); press(4'b1000); press(4'b0001);
    watch(20, fl, bad);
    chk(fl == 0 && freq == 3'(cur_frq), "R8 frequency cancel", freq, cur_frq);
    chk(applies == a0, "R8 no apply", applies - a0, 0);

    // R12 simultaneous presses
    commit(4'b0110, 1'b0, 0, 2, "R12 datapath beats format");
    press(4'b1101);
    lamp_on(1, ones);
    chk(ones == DIV, "R12 button 0 wins", ones, DIV);
    a0 = applies;
    press(4'b0111);
    watch(20, fl, bad);
    chk(applies == a0 && fl == 0, "R12 cancel beats select", applies - a0, 0);
    chk(mode == 2'd0, "R12 mode kept", mode, 0);

    finish_run();
  end
endmodule